// File: doc/BRIEF.md
# Second-Harmonic Upstream Fault Trip Relay

This block decides whether to open a microgrid's main breaker from the second-harmonic content measured on the main bus. Each time the front end presents a fresh set of per-phase magnitudes, the block adds the three current second-harmonic values and, separately, the three voltage second-harmonic values. The current total is then placed in one of three bands. Above an upper limit, the sample indicates an unbalanced fault. Between a small noise floor and that limit, it indicates a balanced three-phase fault. At or below the floor, it counts as no harmonic activity.

A trip needs two things at once: a fault class from the current total, and a voltage total above its own limit. Requiring both keeps switching transients from tripping the breaker, because those transients carry much less voltage harmonic than any fault. A per-phase overcurrent compare on the fundamental currents marks a qualifying fault as lying on the microgrid side, and in that case every microgrid breaker is ordered open. The trip and class outputs hold until a clear is applied.

Top module: `h2_trip_relay`

## Requirements
- R1: After reset, trip_main, trip_all, cls_bal, cls_unbal and cls_mgside are all 0.
- R2: A valid sample whose current sum (a+b+c, computed without loss) is above thr_i_hi and whose voltage sum is above thr_v sets trip_main and cls_unbal.
- R3: A valid sample whose current sum is above thr_i_floor and no higher than thr_i_hi, with a voltage sum above thr_v, sets trip_main and cls_bal.
- R4: A valid sample whose current sum is at or below thr_i_floor changes no output, whatever its voltage sum.
- R5: A valid sample whose voltage sum is at or below thr_v changes no output, whatever its current sum.
- R6: A sample that qualifies under R2 or R3 while any phase fundamental current is above thr_oc also sets trip_all and cls_mgside, in addition to trip_main.
- R7: An overcurrent alone, without a qualifying harmonic fault, changes no output.
- R8: Outputs are sticky. Later samples can only add flags. Asserting clr returns every output to 0 on the next edge, and clr wins over a qualifying sample in the same cycle.
- R9: Inputs presented while smp_vld is 0 change no output.
- R10: Three full-scale current inputs sum to 3*(2^MAG_W-1) with no wrap, so with thr_i_hi one below that total the sample is unbalanced, and with thr_i_hi equal to that total it is balanced.
- R11: Outputs change on the clock edge that samples smp_vld high, never before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Marks a new set of magnitudes |
| clr | input | 1 | Clears latched trips and flags |
| ih2_a | input | MAG_W | Phase A current second-harmonic magnitude |
| ih2_b | input | MAG_W | Phase B current second-harmonic magnitude |
| ih2_c | input | MAG_W | Phase C current second-harmonic magnitude |
| vh2_a | input | MAG_W | Phase A voltage second-harmonic magnitude |
| vh2_b | input | MAG_W | Phase B voltage second-harmonic magnitude |
| vh2_c | input | MAG_W | Phase C voltage second-harmonic magnitude |
| ifd_a | input | MAG_W | Phase A fundamental current magnitude |
| ifd_b | input | MAG_W | Phase B fundamental current magnitude |
| ifd_c | input | MAG_W | Phase C fundamental current magnitude |
| thr_i_hi | input | MAG_W+2 | Current-sum limit for the unbalanced class |
| thr_i_floor | input | MAG_W+2 | Current-sum noise floor |
| thr_v | input | MAG_W+2 | Voltage-sum trip limit |
| thr_oc | input | MAG_W | Per-phase overcurrent limit |
| trip_main | output | 1 | Latched main-breaker trip |
| trip_all | output | 1 | Latched trip of all microgrid breakers |
| cls_bal | output | 1 | A balanced fault was seen |
| cls_unbal | output | 1 | An unbalanced fault was seen |
| cls_mgside | output | 1 | A microgrid-side fault was seen |

## Verification
The bench builds the block with MAG_W = 4, so each magnitude takes one of 16 values and each sum lies between 0 and 45. At that width the bench can walk every combination of the three current inputs, every combination of the three voltage inputs, and every combination of the three fundamental currents. Each threshold band edge is therefore hit exactly, and the full-scale sum lands precisely at the top of the range. Short directed sequences on the same build cover stickiness, clearing, the valid gate and the output timing.

// File: rtl/h2_trip_pkg.sv
package h2_trip_pkg;
    localparam int NPH = 3;

    typedef struct packed {
        logic trip_main;
        logic trip_all;
        logic bal;
        logic unbal;
        logic mgside;
    } relay_st_t;
endpackage

// File: rtl/h2_sum3.sv
module h2_sum3
    import h2_trip_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int OUT_W = IN_W + $clog2(NPH)
) (
    input  logic [NPH-1:0][IN_W-1:0] mag,
    output logic [OUT_W-1:0]         total
);
    always_comb begin
        total = '0;
        for (int p = 0; p < NPH; p++) begin
            total = total + OUT_W'(mag[p]);
        end
    end
endmodule

// File: rtl/h2_ovc_detect.sv
module h2_ovc_detect
    import h2_trip_pkg::*;
#(
    parameter int MAG_W = 12
) (
    input  logic [NPH-1:0][MAG_W-1:0] fund,
    input  logic [MAG_W-1:0]          limit,
    output logic                      over
);
    logic [NPH-1:0] ph_over;

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        assign ph_over[p] = fund[p] > limit;
    end

    assign over = |ph_over;
endmodule

// File: rtl/h2_classifier.sv
module h2_classifier #(
    parameter int SUM_W = 14
) (
    input  logic [SUM_W-1:0] isum,
    input  logic [SUM_W-1:0] vsum,
    input  logic [SUM_W-1:0] lim_hi,
    input  logic [SUM_W-1:0] lim_floor,
    input  logic [SUM_W-1:0] lim_v,
    output logic             is_bal,
    output logic             is_unbal,
    output logic             v_hit
);
    always_comb begin
        is_unbal = isum > lim_hi;
        is_bal   = (isum > lim_floor) && !is_unbal;
        v_hit    = vsum > lim_v;
    end
endmodule

// File: rtl/h2_trip_relay.sv
module h2_trip_relay
    import h2_trip_pkg::*;
#(
    parameter int MAG_W = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           smp_vld,
    input  logic                           clr,
    input  logic [MAG_W-1:0]               ih2_a,
    input  logic [MAG_W-1:0]               ih2_b,
    input  logic [MAG_W-1:0]               ih2_c,
    input  logic [MAG_W-1:0]               vh2_a,
    input  logic [MAG_W-1:0]               vh2_b,
    input  logic [MAG_W-1:0]               vh2_c,
    input  logic [MAG_W-1:0]               ifd_a,
    input  logic [MAG_W-1:0]               ifd_b,
    input  logic [MAG_W-1:0]               ifd_c,
    input  logic [MAG_W+$clog2(NPH)-1:0]   thr_i_hi,
    input  logic [MAG_W+$clog2(NPH)-1:0]   thr_i_floor,
    input  logic [MAG_W+$clog2(NPH)-1:0]   thr_v,
    input  logic [MAG_W-1:0]               thr_oc,
    output logic                           trip_main,
    output logic                           trip_all,
    output logic                           cls_bal,
    output logic                           cls_unbal,
    output logic                           cls_mgside
);
    localparam int SUM_W = MAG_W + $clog2(NPH);

    logic [NPH-1:0][MAG_W-1:0] cur_vec, volt_vec, fund_vec;
    logic [SUM_W-1:0]          isum, vsum;
    logic                      is_bal, is_unbal, v_hit, oc_hit, fault;
    relay_st_t                 st_d, st_q;

    assign cur_vec  = {ih2_c, ih2_b, ih2_a};
    assign volt_vec = {vh2_c, vh2_b, vh2_a};
    assign fund_vec = {ifd_c, ifd_b, ifd_a};

    h2_sum3 #(.IN_W(MAG_W), .OUT_W(SUM_W)) u_isum (
        .mag   (cur_vec),
        .total (isum)
    );

    h2_sum3 #(.IN_W(MAG_W), .OUT_W(SUM_W)) u_vsum (
        .mag   (volt_vec),
        .total (vsum)
    );

    h2_classifier #(.SUM_W(SUM_W)) u_cls (
        .isum      (isum),
        .vsum      (vsum),
        .lim_hi    (thr_i_hi),
        .lim_floor (thr_i_floor),
        .lim_v     (thr_v),
        .is_bal    (is_bal),
        .is_unbal  (is_unbal),
        .v_hit     (v_hit)
    );

    h2_ovc_detect #(.MAG_W(MAG_W)) u_ovc (
        .fund  (fund_vec),
        .limit (thr_oc),
        .over  (oc_hit)
    );

    assign fault = smp_vld && v_hit && (is_bal || is_unbal);

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (fault) begin
            st_d.trip_main = 1'b1;
            st_d.bal       = st_q.bal   | is_bal;
            st_d.unbal     = st_q.unbal | is_unbal;
            if (oc_hit) begin
                st_d.trip_all = 1'b1;
                st_d.mgside   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trip_main  = st_q.trip_main;
    assign trip_all   = st_q.trip_all;
    assign cls_bal    = st_q.bal;
    assign cls_unbal  = st_q.unbal;
    assign cls_mgside = st_q.mgside;
endmodule

// File: rtl/h2_trip_relay_chk.sv
module h2_trip_relay_chk (
    input logic clk,
    input logic rst_n,
    input logic smp_vld,
    input logic clr,
    input logic trip_main,
    input logic trip_all,
    input logic cls_bal,
    input logic cls_unbal,
    input logic cls_mgside
);
    logic [4:0] outs;
    assign outs = {trip_main, trip_all, cls_bal, cls_unbal, cls_mgside};

    // R6
    all_implies_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip_all |-> (trip_main && cls_mgside));

    // R11
    rise_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_main) |-> $past(smp_vld));

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !smp_vld) |=> $stable(outs));

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (outs == 5'b0));

    // R2
    trip_has_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_main) |-> (cls_bal || cls_unbal));
endmodule

bind h2_trip_relay h2_trip_relay_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_vld    (smp_vld),
    .clr        (clr),
    .trip_main  (trip_main),
    .trip_all   (trip_all),
    .cls_bal    (cls_bal),
    .cls_unbal  (cls_unbal),
    .cls_mgside (cls_mgside)
);

// File: tb/sim_h2_trip_relay.sv
`timescale 1ns/1ps
module sim_h2_trip_relay;
    localparam int MW = 4;
    localparam int SW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic clr = 1'b0;
    logic [MW-1:0] ia = '0, ib = '0, ic = '0;
    logic [MW-1:0] va = '0, vb = '0, vc = '0;
    logic [MW-1:0] fa = '0, fb = '0, fc = '0;
    logic [SW-1:0] t_hi = '0, t_fl = '0, t_v = '0;
    logic [MW-1:0] t_oc = '0;
    logic trip_main, trip_all, cls_bal, cls_unbal, cls_mgside;

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    h2_trip_relay #(.MAG_W(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .clr(clr),
        .ih2_a(ia), .ih2_b(ib), .ih2_c(ic),
        .vh2_a(va), .vh2_b(vb), .vh2_c(vc),
        .ifd_a(fa), .ifd_b(fb), .ifd_c(fc),
        .thr_i_hi(t_hi), .thr_i_floor(t_fl), .thr_v(t_v), .thr_oc(t_oc),
        .trip_main(trip_main), .trip_all(trip_all), .cls_bal(cls_bal),
        .cls_unbal(cls_unbal), .cls_mgside(cls_mgside)
    );

    function automatic logic [4:0] outs_now();
        return {trip_main, trip_all, cls_bal, cls_unbal, cls_mgside};
    endfunction

    // {main, all, bal, unbal, mgside} for one sample from a cleared state
    function automatic logic [4:0] model(input int is, input int vs, input int fmax);
        logic ub, bl, vh, oc, f;
        ub = is > int'(t_hi);
        bl = (is > int'(t_fl)) && !ub;
        vh = vs > int'(t_v);
        oc = fmax > int'(t_oc);
        f  = vh && (ub || bl);
        return {f, f && oc, f && bl, f && ub, f && oc};
    endfunction

    function automatic string tag_of(input int is, input int vs, input int fmax);
        if (vs <= int'(t_v)) return "R5";
        if (is <= int'(t_fl)) return "R4";
        if (fmax > int'(t_oc)) return "R6";
        if (is > int'(t_hi)) return "R2";
        return "R3";
    endfunction

    task automatic check(input string tag, input logic [4:0] exp);
        n_cmp++;
        if (outs_now() !== exp) begin
            n_bad++;
            $display("FAIL %s: outputs %b expected %b", tag, outs_now(), exp);
        end
    endtask

    task automatic load(input int a, b, c, input int x, y, z, input int p, q, r);
        ia = MW'(a); ib = MW'(b); ic = MW'(c);
        va = MW'(x); vb = MW'(y); vc = MW'(z);
        fa = MW'(p); fb = MW'(q); fc = MW'(r);
    endtask

    task automatic pulse_sample();
        @(negedge clk);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic sweep_one(input int a, b, c, input int x, y, z, input int p, q, r);
        int fm;
        fm = (p > q) ? p : q;
        fm = (fm > r) ? fm : r;
        load(a, b, c, x, y, z, p, q, r);
        pulse_sample();
        check(tag_of(a + b + c, x + y + z, fm), model(a + b + c, x + y + z, fm));
        do_clear();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #950000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: outputs %b expected run end", outs_now());
            finish_run();
        end
    end

    initial begin
        t_hi = 6'd20; t_fl = 6'd2; t_v = 6'd20; t_oc = 4'd9;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", 5'b00000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 5'b00000);

        // R2 R3 R4: every current combination, voltage well above limit
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int c = 0; c < 16; c++)
                    sweep_one(a, b, c, 15, 15, 15, 0, 0, 0);

        // R5: every voltage combination, current in the unbalanced band
        t_v = 6'd25;
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
                for (int z = 0; z < 16; z++)
                    sweep_one(10, 10, 10, x, y, z, 0, 0, 0);

        // R6: every fundamental combination under a balanced fault
        t_v = 6'd20;
        for (int p = 0; p < 16; p++)
            for (int q = 0; q < 16; q++)
                for (int r = 0; r < 16; r++)
                    sweep_one(4, 3, 3, 15, 15, 15, p, q, r);

        // R7: overcurrent with no qualifying harmonic fault
        for (int p = 0; p < 16; p++) begin
            sweep_one(0, 1, 0, 15, 15, 15, p, 15, p);
            sweep_one(15, 15, 15, 1, 1, 1, 15, p, p);
        end

        // R10: full-scale sum sits exactly at 45
        t_hi = 6'd44;
        sweep_one(15, 15, 15, 15, 15, 15, 0, 0, 0);
        load(15, 15, 15, 15, 15, 15, 0, 0, 0);
        t_hi = 6'd45;
        pulse_sample();
        check("R10", 5'b10100);
        do_clear();
        t_hi = 6'd20;

        // R9: qualifying inputs without the valid strobe
        load(15, 15, 15, 15, 15, 15, 15, 15, 15);
        repeat (4) @(negedge clk);
        check("R9", 5'b00000);

        // R11: nothing moves before the sampling edge
        @(negedge clk);
        smp_vld = 1'b1;
        #1;
        check("R11", 5'b00000);
        @(negedge clk);
        smp_vld = 1'b0;
        check("R11", 5'b11011);
        do_clear();
        check("R8", 5'b00000);

        // R8: flags accumulate and hold
        load(10, 10, 10, 15, 15, 15, 0, 0, 0);
        pulse_sample();
        check("R8", 5'b10010);
        load(4, 3, 3, 15, 15, 15, 0, 0, 0);
        pulse_sample();
        check("R8", 5'b10110);
        load(0, 0, 0, 0, 0, 0, 0, 0, 0);
        pulse_sample();
        repeat (3) @(negedge clk);
        check("R8", 5'b10110);

        // R8: clear beats a same-cycle microgrid-side fault
        load(10, 10, 10, 15, 15, 15, 15, 0, 0);
        @(negedge clk);
        clr = 1'b1;
        smp_vld = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        smp_vld = 1'b0;
        check("R8", 5'b00000);
        pulse_sample();
        check("R6", 5'b11011);

        done = 1'b1;
        finish_run();
    end
endmodule